// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Multiplexer

This block turns one 40-bit parallel word into serial streams on up to eight output lanes. A 3-bit modulus select splits the word into a number of lanes of equal width. Each lane sends its slice of the word one bit per clock, starting with the least significant bit. An external timing block pulses a load strobe once per modulus period. On that edge the block captures the next word and restarts every lane at its first bit.

Around the serializer sit four controls. Two active-low blanking requests zero a whole word period. An address pass-through, enabled low, sends five address inputs to fixed lanes one clock later. An asynchronous mute forces every lane low. An edge-select bit picks whether the lanes change on the rising or the falling clock edge.

Top module: `par_ser_mux`

## Requirements
- R1: The modulus select is latched at a load edge. Codes 0..7 give (lanes x bits): 0 = 8x4, 1 = 8x5, 2 = 5x8, 3 = 4x10, 4 = 2x16, 5 = 2x20, 6 = 1x32, 7 = 1x40.
- R2: With n the lane width, lane k carries word bits [k*n +: n], LSB first. With edge select low, bit j of every lane is on the lanes after the (j+1)-th rising edge that follows the load edge.
- R3: A load edge captures the word and restarts at bit 0. Without a load, a lane wraps to bit 0 after n bits and repeats the held word.
- R4: Lanes with an index at or above the lane count of the latched mode are driven 0.
- R5: A change of the modulus select between load edges has no effect until the next load edge.
- R6: Blanking is requested by sampling either blank input low on a rising edge. A request from any edge after the previous load edge, up to and including a load edge, forces all lanes to 0 for the n outputs of the word loaded there. The following word is not blanked when no new request arrives.
- R7: An address-enable input sampled low on a rising edge drives lanes 0, 2, 4, 6 and 7 with address bits 0, 1, 2, 3 and 4 from that edge. The remaining lanes are driven 0 until the next rising edge. Blanking does not apply to these outputs.
- R8: While address enable is high, the address inputs have no effect on the lanes.
- R9: Mute high forces all lanes to 0 at once, without waiting for a clock edge. Releasing mute restores the registered value.
- R10: With edge select high, the lanes show the same sequence but update half a cycle later, on the falling edge.
- R11: Reset drives all lanes to 0 and selects mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_sel_i | input | 3 | Modulus select, latched at load |
| load_i | input | 1 | Modulus boundary strobe |
| par_i | input | 40 | Parallel word |
| hblank_ni | input | 1 | Horizontal blank request, active low |
| vblank_ni | input | 1 | Vertical blank request, active low |
| addr_en_ni | input | 1 | Address pass-through enable, active low |
| addr_i | input | 5 | Address bits |
| mute_i | input | 1 | Forces all lanes low, asynchronous |
| edge_sel_i | input | 1 | 0: update on rising edge, 1: on falling edge |
| lanes_o | output | 8 | Serial output lanes |

## Verification
The serializer is driven in all eight modes with a random word each time, so every lane's slice and bit order is compared against a model. Mode 2 also shows that lanes 5..7 stay zero. Holding a word without a new load separates a correct wrap from a stalled or free-running counter. A select change in mid-word separates a latched mode from a live one. A one-cycle blank pulse followed by an unblanked word checks that a request covers exactly one word. Toggling the address bits while the pass-through is off, and the same bits with it on, shows the bypass is gated by its enable. Sampling either side of the falling edge with edge select high shows the half-cycle shift.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam int WORD_W = 40;
  localparam int LANE_N = 8;
  localparam int ADDR_W = 5;
  localparam int MODE_W = 3;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int LCNT_W = $clog2(LANE_N + 1);

  typedef logic [MODE_W-1:0] mode_t;

  function automatic logic [CNT_W-1:0] mode_width(mode_t m);
    case (m)
      3'd0: mode_width = CNT_W'(4);
      3'd1: mode_width = CNT_W'(5);
      3'd2: mode_width = CNT_W'(8);
      3'd3: mode_width = CNT_W'(10);
      3'd4: mode_width = CNT_W'(16);
      3'd5: mode_width = CNT_W'(20);
      3'd6: mode_width = CNT_W'(32);
      default: mode_width = CNT_W'(40);
    endcase
  endfunction

  function automatic logic [LCNT_W-1:0] mode_lanes(mode_t m);
    case (m)
      3'd0, 3'd1: mode_lanes = LCNT_W'(8);
      3'd2:       mode_lanes = LCNT_W'(5);
      3'd3:       mode_lanes = LCNT_W'(4);
      3'd4, 3'd5: mode_lanes = LCNT_W'(2);
      default:    mode_lanes = LCNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/psm_ctrl.sv
module psm_ctrl
  import psm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  mode_t            mod_sel_i,
  input  logic             blank_req_i,
  output mode_t            mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             blank_o
);
  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, blank_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = mode_width(mode_q) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      blank_q <= 1'b0;
    end else if (load_i) begin
      mode_q  <= mod_sel_i;
      cnt_q   <= '0;
      blank_q <= pend_q | blank_req_i;
      pend_q  <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == last_idx) ? '0 : cnt_q + CNT_W'(1);
      pend_q <= pend_q | blank_req_i;
    end
  end

  assign mode_o  = mode_q;
  assign cnt_o   = cnt_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/psm_lanes.sv
module psm_lanes
  import psm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] par_i,
  input  mode_t             mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [LANE_N-1:0] bits_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= par_i;
  end

  for (genvar k = 0; k < LANE_N; k++) begin : g_lane
    int idx;
    always_comb begin
      idx = k * int'(mode_width(mode_i)) + int'(cnt_i);
      if (k < int'(mode_lanes(mode_i)) && idx < WORD_W)
        bits_o[k] = word_q[idx];
      else
        bits_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/psm_out.sv
module psm_out
  import psm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_N-1:0] bits_i,
  input  logic              blank_i,
  input  logic              addr_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mute_i,
  input  logic              edge_sel_i,
  output logic [LANE_N-1:0] lanes_o
);
  logic [LANE_N-1:0] addr_map, nxt, pos_q, neg_q;

  // address bits land on lanes 0,2,4,6,7
  always_comb begin
    addr_map    = '0;
    addr_map[0] = addr_i[0];
    addr_map[2] = addr_i[1];
    addr_map[4] = addr_i[2];
    addr_map[6] = addr_i[3];
    addr_map[7] = addr_i[4];
  end

  assign nxt = !addr_en_ni ? addr_map : (blank_i ? '0 : bits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= nxt;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= pos_q;
  end

  assign lanes_o = mute_i ? '0 : (edge_sel_i ? neg_q : pos_q);
endmodule

// File: rtl/par_ser_mux.sv
module par_ser_mux
  import psm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mod_sel_i,
  input  logic              load_i,
  input  logic [39:0]       par_i,
  input  logic              hblank_ni,
  input  logic              vblank_ni,
  input  logic              addr_en_ni,
  input  logic [4:0]        addr_i,
  input  logic              mute_i,
  input  logic              edge_sel_i,
  output logic [7:0]        lanes_o
);
  mode_t             mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              blank_q;
  logic [LANE_N-1:0] lane_bits;

  psm_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .mod_sel_i   (mod_sel_i),
    .blank_req_i (!hblank_ni || !vblank_ni),
    .mode_o      (mode_q),
    .cnt_o       (cnt_q),
    .blank_o     (blank_q)
  );

  psm_lanes u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .par_i  (par_i),
    .mode_i (mode_q),
    .cnt_i  (cnt_q),
    .bits_o (lane_bits)
  );

  psm_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bits_i     (lane_bits),
    .blank_i    (blank_q),
    .addr_en_ni (addr_en_ni),
    .addr_i     (addr_i),
    .mute_i     (mute_i),
    .edge_sel_i (edge_sel_i),
    .lanes_o    (lanes_o)
  );
endmodule

// File: rtl/psm_chk.sv
module psm_chk
  import psm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             addr_en_ni,
  input logic [4:0]       addr_i,
  input logic             mute_i,
  input logic             edge_sel_i,
  input logic [7:0]       lanes_o,
  input mode_t            mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             blank_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  function automatic logic [7:0] used_mask(mode_t m);
    used_mask = 8'((9'd1 << mode_lanes(m)) - 9'd1);
  endfunction

  AST_MUTE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |-> lanes_o == 8'h00); // R9

  AST_ADDR_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mute_i && !edge_sel_i && $past(!addr_en_ni)) |->
      lanes_o == {$past(addr_i[4]), $past(addr_i[3]), 1'b0, $past(addr_i[2]),
                  1'b0, $past(addr_i[1]), 1'b0, $past(addr_i[0])}); // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mute_i && !edge_sel_i && $past(addr_en_ni)) |->
      (lanes_o & ~used_mask($past(mode_q))) == 8'h00); // R4

  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mute_i && !edge_sel_i && $past(addr_en_ni) && $past(blank_q)) |->
      lanes_o == 8'h00); // R6

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < mode_width(mode_q)); // R3

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !load_i) |=> $stable(mode_q)); // R5
endmodule

bind par_ser_mux psm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .addr_en_ni (addr_en_ni),
  .addr_i     (addr_i),
  .mute_i     (mute_i),
  .edge_sel_i (edge_sel_i),
  .lanes_o    (lanes_o),
  .mode_q     (mode_q),
  .cnt_q      (cnt_q),
  .blank_q    (blank_q)
);

// File: tb/par_ser_mux_tb.sv
`timescale 1ns/1ps
module par_ser_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mod_sel = '0;
  logic        load = 1'b0;
  logic [39:0] par = '0;
  logic        hblank_n = 1'b1, vblank_n = 1'b1;
  logic        addr_en_n = 1'b1;
  logic [4:0]  addr = '0;
  logic        mute = 1'b0, edge_sel = 1'b0;
  logic [7:0]  lanes;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  par_ser_mux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mod_sel_i(mod_sel), .load_i(load),
    .par_i(par), .hblank_ni(hblank_n), .vblank_ni(vblank_n),
    .addr_en_ni(addr_en_n), .addr_i(addr), .mute_i(mute),
    .edge_sel_i(edge_sel), .lanes_o(lanes)
  );

  function automatic int w_of(int m);
    int t[8] = '{4, 5, 8, 10, 16, 20, 32, 40};
    return t[m];
  endfunction
  function automatic int l_of(int m);
    int t[8] = '{8, 8, 5, 4, 2, 2, 1, 1};
    return t[m];
  endfunction
  function automatic logic [7:0] exp_bits(int m, logic [39:0] w, int j);
    logic [7:0] r = '0;
    for (int k = 0; k < l_of(m); k++) r[k] = w[k * w_of(m) + j];
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lanes actual %b expected %b", req, act, exp);
    end
  endtask

  // load word in mode m; mod_sel switched to m_after after load; reps word periods without reload
  task automatic run_word(int m, logic [39:0] w, int m_after, int reps, bit blanked, string req);
    @(negedge clk); load = 1'b1; par = w; mod_sel = 3'(m);
    @(negedge clk); load = 1'b0; par = ~w; mod_sel = 3'(m_after);
    for (int r = 0; r < reps; r++)
      for (int j = 0; j < w_of(m); j++) begin
        @(negedge clk);
        check(req, lanes, blanked ? 8'h00 : exp_bits(m, w, j));
        addr = 5'($urandom); // R8: ignored while enable high
      end
  endtask

  task automatic t_reset();
    check("R11", lanes, 8'h00);
  endtask

  task automatic t_all_modes();
    for (int m = 0; m < 8; m++)
      run_word(m, {$urandom, $urandom}, m, 1, 1'b0, "R1/R2/R4/R8");
  endtask

  task automatic t_wrap();
    run_word(0, 40'hA5_C3_96_1E_7B, 0, 3, 1'b0, "R3");
  endtask

  task automatic t_mode_hold();
    run_word(2, 40'h12_34_56_78_9A, 7, 1, 1'b0, "R5");
  endtask

  task automatic t_blank();
    @(negedge clk); hblank_n = 1'b0;
    @(negedge clk); hblank_n = 1'b1;
    run_word(1, 40'hFF_FF_FF_FF_FF, 1, 1, 1'b1, "R6");
    run_word(1, 40'hF0_0F_AA_55_C3, 1, 1, 1'b0, "R6");
    @(negedge clk); vblank_n = 1'b0;
    @(negedge clk); vblank_n = 1'b1;
    run_word(3, 40'hDE_AD_BE_EF_01, 3, 1, 1'b1, "R6");
  endtask

  task automatic t_addr();
    logic [4:0] v = 5'b10110;
    @(negedge clk); addr_en_n = 1'b0; addr = v;
    @(negedge clk);
    check("R7", lanes, {v[4], v[3], 1'b0, v[2], 1'b0, v[1], 1'b0, v[0]});
    v = 5'b01001; addr = v;
    @(negedge clk);
    check("R7", lanes, {v[4], v[3], 1'b0, v[2], 1'b0, v[1], 1'b0, v[0]});
    addr_en_n = 1'b1;
  endtask

  task automatic t_mute();
    logic [39:0] w = 40'hFF_FF_FF_FF_FF;
    @(negedge clk); load = 1'b1; par = w; mod_sel = 3'd0;
    @(negedge clk); load = 1'b0;
    @(negedge clk);
    check("R9", lanes, 8'hFF);
    mute = 1'b1; #1;
    check("R9", lanes, 8'h00);
    mute = 1'b0; #1;
    check("R9", lanes, 8'hFF);
  endtask

  task automatic t_edge();
    logic [39:0] w = 40'h3C_5A_96_0F_E1;
    @(negedge clk); edge_sel = 1'b1; load = 1'b1; par = w; mod_sel = 3'd0;
    @(negedge clk); load = 1'b0;
    for (int j = 0; j < 4; j++) begin
      @(posedge clk); #2;
      if (j > 0) check("R10", lanes, exp_bits(0, w, j - 1));
      @(negedge clk); #1;
      check("R10", lanes, exp_bits(0, w, j));
    end
    edge_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_all_modes();
    t_wrap();
    t_mode_hold();
    t_blank();
    t_addr();
    t_mute();
    t_edge();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule